// File: doc/BRIEF.md
# Dual Performance Counter Unit

The unit keeps two 32-bit event counters for a processor core. Both counters are seen by software as the two halves of one 64-bit counter register: counter index 0 sits in bits 63:32 and counter index 1 in bits 31:0. A single control register picks, for each counter, which of sixteen per-cycle event pulses it follows. It also holds three privilege enable bits that both counters share, and an interrupt enable.

Neither counter can be stopped on its own, because the privilege enables gate both at once. Software parks an idle counter by selecting event code 15, which never counts. To sample every N events, software preloads a counter with the two's complement of N. The counter then wraps from all ones to zero on the N-th event, which sets a sticky overflow flag. The interrupt line is the OR of the two flags, masked by the interrupt enable.

Registers are written through a simple one-cycle write port with two half-word enables and read through a combinational read port. Register codes: 0 is control, 1 is the counter pair, 2 is the overflow flags.

Top module: `dual_perf_counter`

## Requirements
- R1: After reset both counters, the control register and both overflow flags read zero and `irq` is low.
- R2: On a clock edge a counter adds exactly one when the pulse named by its select field is high and counting is allowed. In the control register the select field for counter index 0 is bits 19:16 and for counter index 1 is bits 11:8.
- R3: When a counter advances from 0xFFFFFFFF it becomes 0 and sets its overflow flag. In the flag register the flag for index 0 is bit 0 and for index 1 is bit 1. The flag holds until it is cleared.
- R4: `irq` is high exactly when the interrupt enable (control bit 3) is set and at least one overflow flag is set.
- R5: Writing the flag register with half enable 0 set clears each flag whose data bit is 1. Data bits of 0 leave the flags unchanged.
- R6: Counting is allowed only when the `ctx` input names a context whose enable bit is set. Code 0 is user (control bit 0), code 1 is supervisor (bit 1), code 2 is hypervisor (bit 2), and code 3 never counts. With all three bits clear neither counter moves.
- R7: Select code 15 never counts, whatever the event pulses do.
- R8: A counter-register write changes only the halves whose enable is set. `wr_be[1]` covers bits 63:32 and `wr_be[0]` covers bits 31:0. A control write takes effect only with `wr_be[0]` set.
- R9: A write to a counter half in the same cycle as a counted event loads the written value, and the event is dropped.
- R10: A counter preloaded with the two's complement of N raises its flag on the N-th counted event and not before.
- R11: The two counters follow their own select fields independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx | input | 2 | Current privilege context (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| evt_pulse | input | 16 | Per-cycle event pulses, one per select code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register code for the write |
| wr_be | input | 2 | Half enables: bit 1 for bits 63:32, bit 0 for bits 31:0 |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Register code for the read |
| rd_data | output | 64 | Read data (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
Each write, each counted event and each wrap lands in state at the next rising edge. It shows on `rd_data` and on `irq` as soon as that edge has settled, because both outputs are combinational functions of registers. The bench drives its inputs one time unit after a rising edge and samples right after the following edge. Every check therefore sees exactly one edge's worth of change, and the expected counts and flags are advanced once per edge in the bench model.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        CTX_USER  = 2'd0,
        CTX_SUPER = 2'd1,
        CTX_HYPER = 2'd2,
        CTX_NONE  = 2'd3
    } ctx_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_FLAGS = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    localparam int EN_USER_BIT  = 0;
    localparam int EN_SUPER_BIT = 1;
    localparam int EN_HYPER_BIT = 2;
    localparam int IRQ_EN_BIT   = 3;
    localparam int NUM_CTR      = 2;
endpackage

// File: rtl/dpc_ctx_gate.sv
module dpc_ctx_gate
    import dpc_pkg::*;
(
    input  logic [2:0] ctx_en,
    input  logic [1:0] ctx,
    output logic       count_ok
);
    ctx_e cur;
    assign cur = ctx_e'(ctx);

    always_comb begin
        unique case (cur)
            CTX_USER:  count_ok = ctx_en[EN_USER_BIT];
            CTX_SUPER: count_ok = ctx_en[EN_SUPER_BIT];
            CTX_HYPER: count_ok = ctx_en[EN_HYPER_BIT];
            default:   count_ok = 1'b0;
        endcase
    end

    // R6: no enable set means no counting in any context
    always_comb begin
        if (ctx_en == 3'b000) assert_gate_closed_R6: assert (!count_ok);
    end
endmodule

// File: rtl/dpc_counter.sv
module dpc_counter #(
    parameter int CW    = 32,
    parameter int EVT_W = 4,
    localparam int NUM_EVT = 1 << EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_ok,
    input  logic [EVT_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               load,
    input  logic [CW-1:0]      load_val,
    input  logic               clr_flag,
    output logic [CW-1:0]      count,
    output logic               flag,
    output logic               wrap
);
    localparam logic [EVT_W-1:0] PARK_CODE = '1;
    localparam logic [CW-1:0]    ALL_ONES  = '1;

    logic hit;
    assign hit  = count_ok && (sel != PARK_CODE) && evt_pulse[sel];
    assign wrap = hit && !load && (count == ALL_ONES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (hit)   count <= count + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= wrap | (flag & ~clr_flag);
    end

    // R2: without a load a counter moves by at most one per edge
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count == $past(count) || count == $past(count) + CW'(1)));
    // R7: parked code holds the count
    assert_park_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PARK_CODE && !load) |=> $stable(count));
    // R3: wrap lands at zero with the flag raised
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag && count == '0));
    // R9: load beats a same-cycle event
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R5: clearing without a wrap drops the flag
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !wrap) |=> !flag);
endmodule

// File: rtl/dual_perf_counter.sv
module dual_perf_counter
    import dpc_pkg::*;
#(
    parameter int CW       = 32,
    parameter int EVT_W    = 4,
    parameter int LO_SHIFT = 8,
    parameter int HI_SHIFT = 16,
    localparam int NUM_EVT = 1 << EVT_W,
    localparam int DW      = NUM_CTR * CW,
    localparam int CTRL_W  = HI_SHIFT + EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ctx,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [1:0]         wr_be,
    input  logic [DW-1:0]      wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic               irq
);
    logic [CTRL_W-1:0]  ctrl;
    logic               count_ok;
    logic [CW-1:0]      cnt   [NUM_CTR];
    logic [NUM_CTR-1:0] flags;
    logic [NUM_CTR-1:0] wraps;
    reg_addr_e          wa, ra;

    assign wa = reg_addr_e'(wr_addr);
    assign ra = reg_addr_e'(rd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_en && wa == RA_CTRL && wr_be[0]) ctrl <= wr_data[CTRL_W-1:0];
    end

    dpc_ctx_gate u_gate (
        .ctx_en   (ctrl[EN_HYPER_BIT:EN_USER_BIT]),
        .ctx      (ctx),
        .count_ok (count_ok)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam int SHIFT = (i == 0) ? HI_SHIFT : LO_SHIFT;
        localparam int TOP   = (NUM_CTR - i) * CW - 1;
        logic load, clr;
        assign load = wr_en && (wa == RA_COUNT) && wr_be[NUM_CTR-1-i];
        assign clr  = wr_en && (wa == RA_FLAGS) && wr_be[0] && wr_data[i];
        dpc_counter #(.CW(CW), .EVT_W(EVT_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .count_ok  (count_ok),
            .sel       (ctrl[SHIFT +: EVT_W]),
            .evt_pulse (evt_pulse),
            .load      (load),
            .load_val  (wr_data[TOP -: CW]),
            .clr_flag  (clr),
            .count     (cnt[i]),
            .flag      (flags[i]),
            .wrap      (wraps[i])
        );
    end

    assign irq = ctrl[IRQ_EN_BIT] && (|flags);

    always_comb begin
        unique case (ra)
            RA_CTRL:  rd_data = DW'(ctrl);
            RA_COUNT: rd_data = {cnt[0], cnt[1]};
            RA_FLAGS: rd_data = DW'(flags);
            default:  rd_data = '0;
        endcase
    end

    // R4: a wrap with interrupts enabled raises irq on the next edge
    assert_wrap_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[IRQ_EN_BIT] && (|wraps) && !(wr_en && wa == RA_CTRL)) |=> irq);
    // R8: upper-only counter write leaves the lower counter to its own events
    assert_half_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == RA_COUNT && wr_be == 2'b10)
        |=> (cnt[1] == $past(cnt[1]) || cnt[1] == $past(cnt[1]) + CW'(1)));
    // R1: nothing pending right out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0 && !irq));
endmodule

// File: tb/dual_perf_counter_test.sv
module dual_perf_counter_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  ctx = 0;
    logic [15:0] evt_pulse = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [1:0]  wr_be = 0;
    logic [63:0] wr_data = 0;
    logic [1:0]  rd_addr = 0;
    logic [63:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] e_hi, e_lo;

    always #5 clk = ~clk;

    dual_perf_counter uut (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [63:0] d, logic [1:0] be);
        wr_en = 1; wr_addr = a; wr_data = d; wr_be = be;
        tick();
        wr_en = 0; wr_be = 0;
    endtask

    function automatic logic [63:0] mk_ctrl(logic [2:0] en, logic ien,
                                            logic [3:0] shi, logic [3:0] slo);
        return 64'(shi) << 16 | 64'(slo) << 8 | 64'(ien) << 3 | 64'(en);
    endfunction

    task automatic rd_cnt(output logic [63:0] v);
        rd_addr = 2'd1; #0; v = rd_data;
    endtask

    initial begin
        logic [63:0] v;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset state
        rd_addr = 0; #1 chk("R1 ctrl", rd_data, 0);
        rd_addr = 1; #1 chk("R1 count", rd_data, 0);
        rd_addr = 2; #1 chk("R1 flags", rd_data, 0);
        chk("R1 irq", 64'(irq), 0);

        // R2 R7 R11 select sweep
        e_hi = 0; e_lo = 0; ctx = 0;
        for (int c = 0; c < 16; c++) begin
            int cl = (c + 5) % 16;
            wr(2'd0, mk_ctrl(3'b001, 0, 4'(c), 4'(cl)), 2'b01);
            for (int b = 0; b < 16; b++) begin
                evt_pulse = 16'(1) << b;
                tick();
                evt_pulse = 0;
                if (b == c && c != 15) e_hi++;
                if (b == cl && cl != 15) e_lo++;
                rd_cnt(v);
                chk(c == 15 ? "R7 park hi" : "R2 R11 hi", 64'(v[63:32]), 64'(e_hi));
                chk(cl == 15 ? "R7 park lo" : "R2 R11 lo", 64'(v[31:0]), 64'(e_lo));
            end
        end
        // R7 all pulses high with both parked
        wr(2'd0, mk_ctrl(3'b111, 0, 4'hf, 4'hf), 2'b01);
        evt_pulse = 16'hffff; repeat (4) tick(); evt_pulse = 0;
        rd_cnt(v); chk("R7 all pulses", v, {e_hi, e_lo});

        // R6 context sweep
        for (int en = 0; en < 8; en++) begin
            wr(2'd0, mk_ctrl(3'(en), 0, 4'd0, 4'd0), 2'b01);
            for (int cx = 0; cx < 4; cx++) begin
                ctx = 2'(cx);
                evt_pulse = 16'h0001;
                tick();
                evt_pulse = 0;
                if (cx != 3 && en[cx]) begin e_hi++; e_lo++; end
                rd_cnt(v);
                chk("R6 ctx gate", v, {e_hi, e_lo});
            end
        end
        ctx = 0;

        // R8 half write: lower only, then control write without be[0]
        wr(2'd1, {32'hdead_beef, 32'hffff_fffb}, 2'b01);
        rd_cnt(v); chk("R8 lower only", v, {e_hi, 32'hffff_fffb});
        wr(2'd0, mk_ctrl(3'b001, 0, 4'hf, 4'd2), 2'b01);
        wr(2'd0, 64'h0, 2'b10);
        rd_addr = 0; #1 chk("R8 ctrl needs be0", rd_data, mk_ctrl(3'b001, 0, 4'hf, 4'd2));

        // R10 preload -5 on lower counter, event code 2
        for (int k = 1; k <= 5; k++) begin
            evt_pulse = 16'h0004; tick(); evt_pulse = 0;
            rd_addr = 2; #1;
            chk("R10 flag timing", rd_data, (k == 5) ? 64'h2 : 64'h0);
        end
        rd_cnt(v); chk("R3 wrap to zero", 64'(v[31:0]), 0);
        chk("R4 irq masked", 64'(irq), 0);
        wr(2'd0, mk_ctrl(3'b001, 1, 4'hf, 4'd2), 2'b01);
        chk("R4 irq enabled", 64'(irq), 1);
        // R5 clearing the wrong bit and zero data
        wr(2'd2, 64'h1, 2'b01);
        rd_addr = 2; #1 chk("R5 other bit", rd_data, 64'h2);
        wr(2'd2, 64'h0, 2'b01);
        rd_addr = 2; #1 chk("R5 zero data", rd_data, 64'h2);
        chk("R3 sticky irq", 64'(irq), 1);
        wr(2'd2, 64'h2, 2'b01);
        rd_addr = 2; #1 chk("R5 cleared", rd_data, 64'h0);
        chk("R4 irq low", 64'(irq), 0);

        // R3 upper counter wrap, flag bit 0
        wr(2'd0, mk_ctrl(3'b001, 1, 4'd7, 4'hf), 2'b01);
        wr(2'd1, {32'hffff_ffff, 32'h0}, 2'b10);
        evt_pulse = 16'h0080; tick(); evt_pulse = 0;
        rd_addr = 2; #1 chk("R3 upper flag", rd_data, 64'h1);
        rd_cnt(v); chk("R3 upper zero", 64'(v[63:32]), 0);
        chk("R4 irq upper", 64'(irq), 1);

        // R9 write with a same-cycle event
        evt_pulse = 16'h0080;
        wr(2'd1, {32'h1234_5678, 32'h0000_0042}, 2'b11);
        evt_pulse = 0;
        rd_cnt(v); chk("R9 write wins", v, {32'h1234_5678, 32'h0000_0042});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule